// File: doc/BRIEF.md
# Coherent-Read Timer Counter

This block is a 16-bit up-counter that runs freely. It is read by an 8-bit processor as two byte-wide registers. The counter moves forward by one in each clock cycle where the prescale enable is high, so its rate follows whatever prescaler drives that enable. The full count is also brought out in parallel for compare logic in the same timer.

A processor that reads the two halves in separate cycles could see a torn value if a carry crosses the byte boundary between the reads. To prevent this, a read of the upper byte also copies the lower byte into a one-entry holding register. A lower-byte read in the very next cycle returns that held copy, so the pair matches the counter as it stood during the upper-byte read. A lower-byte read in any other cycle returns the live lower byte. Software therefore reads upper first, then lower, back to back.

The bus side is read-only. Bus reads never change the count. The asynchronous active-low reset is released through an internal two-stage synchronizer.

Top module: `tcnt_snapread`

## Requirements
- R1: While reset is asserted, `count` is 0x0000 and both byte reads return 0x00.
- R2: In each cycle with `tick_en` high, `count` becomes the previous value plus one.
- R3: In each cycle with `tick_en` low, `count` keeps its value.
- R4: From 0xFFFF, a cycle with `tick_en` high gives 0x0000, and counting continues from there.
- R5: With `rd_en` high and `rd_hi` = 1 (upper byte selected), `rd_data` equals `count[15:8]` in that same cycle.
- R6: A lower-byte read (`rd_en` high, `rd_hi` = 0) in the cycle right after an upper-byte read returns `count[7:0]` as it was during the upper-byte read cycle.
- R7: A lower-byte read that does not directly follow an upper-byte read returns the live `count[7:0]`.
- R8: With `rd_en` low, `rd_data` is 0x00.
- R9: Reads of either byte never alter `count`.
- R10: Each upper-byte read replaces the held copy. After two upper-byte reads in a row, a following lower-byte read returns the copy taken by the second one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Prescale enable; the counter advances in cycles where it is high |
| rd_en | input | 1 | Read strobe for the byte bus |
| rd_hi | input | 1 | Byte select: 1 = upper byte, 0 = lower byte |
| rd_data | output | 8 | Read data; combinational from the current state and the strobe |
| count | output | 16 | Live counter value for compare logic |

## Verification
The hardest case to reach is a coherent pair that straddles a carry out of the lower byte. Here the held copy is 0xFF while the live lower byte has already rolled to 0x00, so a wrong source for the data shows up at once. The stimulus runs the counter, without checks, until its lower byte reads 0xFF. It then issues the upper/lower pair with the enable held high. The same approach runs the counter all the way to 0xFFFF to check the wrap.

// File: rtl/tcnt_pkg.sv
package tcnt_pkg;
  // Byte lane select on the read bus; the encoding is fixed by rd_hi.
  typedef enum logic {
    LANE_LO = 1'b0,
    LANE_HI = 1'b1
  } lane_e;
endpackage

// File: rtl/tcnt_rst_sync.sv
module tcnt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/tcnt_core.sv
module tcnt_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  // Next state: increment on enable; the natural overflow gives the wrap.
  always_comb begin
    cnt_d = cnt_q;
    if (adv) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (adv) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tcnt_snap.sv
module tcnt_snap #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [BYTE_W-1:0] lo_live,
  output logic [BYTE_W-1:0] snap_q,
  output logic              snap_vld_q
);
  logic [BYTE_W-1:0] snap_d;
  logic              vld_d;

  always_comb begin
    snap_d = cap ? lo_live : snap_q;
    vld_d  = cap;  // the copy is valid for exactly one following cycle
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_vld_q <= 1'b0;
    end else begin
      snap_vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= '0;
    end else if (cap) begin
      snap_q <= snap_d;
    end
  end
endmodule

// File: rtl/tcnt_rdmux.sv
module tcnt_rdmux
  import tcnt_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              rd_en,
  input  lane_e             lane,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [BYTE_W-1:0] snap,
  input  logic              snap_vld,
  output logic [BYTE_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (lane)
        LANE_HI: rd_data = cnt[CNT_W-1:BYTE_W];
        LANE_LO: rd_data = snap_vld ? snap : cnt[BYTE_W-1:0];
        default: rd_data = '0;
      endcase
    end
  end
endmodule

// File: rtl/tcnt_snapread.sv
module tcnt_snapread
  import tcnt_pkg::*;
#(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              rd_en,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  count
);
  logic              rst_q_n;
  logic [BYTE_W-1:0] snap;
  logic              snap_vld;
  logic              cap_hi;
  lane_e             lane;

  assign lane   = lane_e'(rd_hi);
  assign cap_hi = rd_en && (lane == LANE_HI);

  tcnt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  tcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst_n (rst_q_n),
    .adv   (tick_en),
    .cnt_q (count)
  );

  tcnt_snap #(.BYTE_W(BYTE_W)) u_snap (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .cap        (cap_hi),
    .lo_live    (count[BYTE_W-1:0]),
    .snap_q     (snap),
    .snap_vld_q (snap_vld)
  );

  tcnt_rdmux #(.CNT_W(CNT_W)) u_mux (
    .rd_en    (rd_en),
    .lane     (lane),
    .cnt      (count),
    .snap     (snap),
    .snap_vld (snap_vld),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/tcnt_snapread_chk.sv
module tcnt_snapread_chk #(
  parameter int CNT_W = 16,
  localparam int BYTE_W = CNT_W / 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              tick_en,
  input logic              rd_en,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] rd_data,
  input logic [CNT_W-1:0]  count
);
  logic armed;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_q_n) begin
      assert_rst_zero_R1: assert (count == '0);
    end
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (!armed)
    tick_en |=> count == $past(count) + CNT_W'(1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!armed)
    !tick_en |=> count == $past(count));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!armed)
    (tick_en && count == '1) |=> count == '0);

  assert_hi_byte_R5: assert property (@(posedge clk) disable iff (!armed)
    (rd_en && rd_hi) |-> rd_data == count[CNT_W-1:BYTE_W]);

  assert_coherent_R6: assert property (@(posedge clk) disable iff (!armed)
    (rd_en && rd_hi) ##1 (rd_en && !rd_hi) |-> rd_data == $past(count[BYTE_W-1:0]));

  assert_live_lo_R7: assert property (@(posedge clk) disable iff (!armed)
    (rd_en && !rd_hi && !$past(rd_en && rd_hi)) |-> rd_data == count[BYTE_W-1:0]);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!armed)
    !rd_en |-> rd_data == '0);

  assert_rdonly_R9: assert property (@(posedge clk) disable iff (!armed)
    (rd_en && !tick_en) |=> $stable(count));
endmodule

bind tcnt_snapread tcnt_snapread_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .tick_en (tick_en),
  .rd_en   (rd_en),
  .rd_hi   (rd_hi),
  .rd_data (rd_data),
  .count   (count)
);

// File: tb/tcnt_snapread_bench.sv
module tcnt_snapread_bench;
  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        rd_en;
  logic        rd_hi;
  logic [7:0]  rd_data;
  logic [15:0] count;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0]  exp_rd;
    logic [15:0] exp_cnt;
    string       req;
  } item_t;

  item_t sb_q[$];

  // Bench-side model, built from the requirements.
  logic [15:0] m_cnt;
  logic [7:0]  m_buf;
  bit          m_vld;

  tcnt_snapread u_tcnt_snapread (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .rd_en   (rd_en),
    .rd_hi   (rd_hi),
    .rd_data (rd_data),
    .count   (count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp, string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: compares one queued item per cycle, away from the active edge.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.req, {8'h00, rd_data}, {8'h00, it.exp_rd}, "rd_data");
      check(it.req, count, it.exp_cnt, "count");
    end
  end

  // Driver: applies one cycle of stimulus, queues the expected result, then
  // advances the model across the coming edge.
  task automatic step(bit t, bit r, bit h, bit chk, string req);
    logic [7:0] e_rd;
    @(posedge clk);
    #1;
    tick_en = t;
    rd_en   = r;
    rd_hi   = h;
    e_rd = 8'h00;
    if (r) e_rd = h ? m_cnt[15:8] : (m_vld ? m_buf : m_cnt[7:0]);
    if (chk) begin
      item_t it;
      it.exp_rd  = e_rd;
      it.exp_cnt = m_cnt;
      it.req     = req;
      sb_q.push_back(it);
    end
    m_vld = r && h;
    if (r && h) m_buf = m_cnt[7:0];
    if (t) m_cnt = m_cnt + 16'd1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    m_cnt = 16'h0000;
    m_buf = 8'h00;
    m_vld = 0;
    rst_n   = 1'b0;
    tick_en = 1'b1;
    rd_en   = 1'b1;
    rd_hi   = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", count, 16'h0000, "count in reset");
    check("R1", {8'h00, rd_data}, 16'h0000, "upper byte in reset");
    rd_hi = 1'b0;
    @(negedge clk);
    check("R1", {8'h00, rd_data}, 16'h0000, "lower byte in reset");
    tick_en = 1'b0;
    rd_en   = 1'b0;
    rst_n   = 1'b1;
    repeat (4) @(posedge clk);

    step(0, 0, 0, 1, "R8");
    step(0, 0, 1, 1, "R8");
    for (int i = 0; i < 10; i++) step(1, 0, 0, 1, "R2");
    // Holding, with reads that must not change the count.
    step(0, 1, 1, 1, "R3");
    step(0, 1, 0, 1, "R9");
    step(0, 1, 0, 1, "R9");
    step(0, 0, 0, 1, "R3");
    // Coherent pair while counting.
    step(1, 1, 1, 1, "R5");
    step(1, 1, 0, 1, "R6");
    step(1, 0, 0, 1, "R2");
    // Upper read, a gap, then a lower read: the lower byte is live.
    step(1, 1, 1, 1, "R5");
    step(1, 0, 0, 1, "R7");
    step(1, 1, 0, 1, "R7");
    step(1, 1, 0, 1, "R7");
    // Back-to-back upper reads refresh the held copy.
    step(1, 1, 1, 1, "R10");
    step(1, 1, 1, 1, "R10");
    step(1, 1, 0, 1, "R10");
    // Pair straddling a carry out of the lower byte.
    while (m_cnt[7:0] != 8'hFF) step(1, 0, 0, 0, "");
    step(1, 1, 1, 1, "R6");
    step(1, 1, 0, 1, "R6");
    step(0, 1, 0, 1, "R7");
    // Wrap from all ones.
    while (m_cnt != 16'hFFFF) step(1, 0, 0, 0, "");
    step(1, 1, 1, 1, "R4");
    step(1, 1, 0, 1, "R4");
    step(0, 0, 0, 1, "R4");
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    report();
    $finish;
  end
endmodule